// File: doc/BRIEF.md
# Serial Bit-Clock Receiver

This block accepts a clean, demodulated asynchronous bit stream (idle high) and re-presents it on a three-wire interface. The three wires are a data line, a data clock and an active-low end-of-word strobe. A plain shift register or a microcontroller port can capture each character from this interface without a UART. Every character has ten cells: a low start bit, eight data bits sent least significant first, and a high stop bit. All timing comes from an oversampling master clock. By default this is a 3.579545 MHz clock divided down to 1200 baud, which gives `BIT_CLKS` = 2983 master clocks per cell, with the count rounded.

A controller FSM has five states.
- **IDLE**: the FSM watches for a high-to-low edge on the line and then moves to **START**.
- **START**: after half a cell the FSM samples the line again. A low line is a confirmed start bit and leads to **DATA**. A high line is a false start and leads back to **IDLE**.
- **DATA**: the FSM samples eight cell centres, one full cell apart, and then moves to **STOP**.
- **STOP**: the FSM samples the stop cell centre. A high level is a good stop and leads to **IDLE**, firing the end-of-word strobe. A low level is a framing error and leads to **WAIT**.
- **WAIT**: the FSM stays here until the line is high again and then goes to **IDLE**.

A separate filter with hysteresis turns a raw carrier flag into an active-low carrier-detect output. A power-down input forces all four outputs high and holds the internal state cleared.

Top module: `bitclk_rx`

## Requirements
- R1: After reset, with power-down low: `data_out`=1, `dclk_out`=0, `dr_n`=1, `cd_n`=1.
- R2: A start bit is taken on a 1-to-0 change of `rx_in`. The line is sampled again HALF=`BIT_CLKS/2` clocks after the first low sample. If it is high, the block returns to IDLE, and produces no clock edge and no strobe.
- R3: Data bit k (k=0..7, least significant first) is sampled at clock t0+HALF+(k+1)·`BIT_CLKS`, where t0 is the clock edge of the first low sample. `data_out` shows the sampled bit, and `dclk_out` rises one clock after that sample.
- R4: Each frame produces exactly eight rising edges of `dclk_out`, and none in the start or stop cell. Each pulse stays high for HALF clocks.
- R5: A stop bit sampled high at clock t0+HALF+9·`BIT_CLKS` drives `dr_n` low from that clock for exactly `BIT_CLKS` clocks.
- R6: A stop bit sampled low is a framing error. `dr_n` stays high, and no new start is accepted until `rx_in` has returned high.
- R7: While `pwdn`=1, all four outputs are 1 and `rx_in` and `carrier_in` are ignored. After release, the outputs are in the reset state.
- R8: `cd_n` falls after `carrier_in` has been 1 for `CD_CLKS` consecutive clocks. It rises after `carrier_in` has been 0 for `CD_CLKS` consecutive clocks. Shorter runs leave it unchanged.
- R9: A start edge that arrives just after a good stop sample is accepted while `dr_n` is still low, so characters sent back to back are all received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwdn | input | 1 | Power-down; 1 quiets the block |
| rx_in | input | 1 | Demodulated serial bit stream, idle high |
| carrier_in | input | 1 | Raw carrier-present flag, 1 = present |
| data_out | output | 1 | Most recently sampled data bit |
| dclk_out | output | 1 | Data clock, rising once per data bit |
| dr_n | output | 1 | End-of-word strobe, active low, one cell wide |
| cd_n | output | 1 | Filtered carrier detect, active low |

## Verification
A wrong cell counter or state changes the clock cycle on which `dclk_out` rises within the same frame. It also changes the number of rising edges before the stop cell. The bench compares both against cycle numbers it computes itself. A lost or spurious good-stop decision shows up at `dr_n` within one cell of the stop sample, as a missing strobe, an extra strobe or a strobe of the wrong width. A stuck WAIT state or start detector corrupts or loses the character that follows, which the bench reads back bit by bit.

// File: rtl/bitclk_rx_pkg.sv
`timescale 1ns/1ps
package bitclk_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_WAIT
    } rx_state_e;
endpackage

// File: rtl/bitclk_rx_fsm.sv
`timescale 1ns/1ps
module bitclk_rx_fsm
    import bitclk_rx_pkg::*;
#(
    parameter int BIT_CLKS = 2983
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          rx,
    output rx_state_e                     state,
    output logic [$clog2(BIT_CLKS+1)-1:0] cnt,
    output logic [3:0]                    nbits,
    output logic                          take_bit,
    output logic                          stop_ok
);
    localparam int CW = $clog2(BIT_CLKS + 1);
    localparam int HALF = BIT_CLKS / 2;
    localparam logic [CW-1:0] LAST_CNT = CW'(BIT_CLKS - 1);
    localparam logic [CW-1:0] HALF_CNT = CW'(HALF - 1);

    rx_state_e       state_n;
    logic [CW-1:0]   cnt_n;
    logic [3:0]      nbits_n;
    logic            prev_rx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            nbits   <= '0;
            prev_rx <= 1'b0;
        end else if (clr) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            nbits   <= '0;
            prev_rx <= 1'b0;
        end else begin
            state   <= state_n;
            cnt     <= cnt_n;
            nbits   <= nbits_n;
            prev_rx <= rx;
        end
    end

    // next state and sample strobes
    always_comb begin
        state_n  = state;
        cnt_n    = cnt;
        nbits_n  = nbits;
        take_bit = 1'b0;
        stop_ok  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cnt_n   = '0;
                nbits_n = '0;
                if (prev_rx && !rx) state_n = ST_START;
            end
            ST_START: begin
                if (cnt == HALF_CNT) begin
                    cnt_n   = '0;
                    state_n = rx ? ST_IDLE : ST_DATA;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            ST_DATA: begin
                if (cnt == LAST_CNT) begin
                    cnt_n    = '0;
                    take_bit = 1'b1;
                    nbits_n  = nbits + 4'd1;
                    if (nbits == 4'd7) state_n = ST_STOP;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            ST_STOP: begin
                if (cnt == LAST_CNT) begin
                    cnt_n = '0;
                    if (rx) begin
                        stop_ok = 1'b1;
                        state_n = ST_IDLE;
                    end else begin
                        state_n = ST_WAIT;
                    end
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            ST_WAIT: begin
                cnt_n = '0;
                if (rx) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // R2: a half-cell check always ends in DATA or IDLE
    p_start_exit_r2: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (state == ST_START && cnt == HALF_CNT) |=> (state == ST_DATA || state == ST_IDLE));
    // R2: a high line at the half-cell check is a false start
    p_false_start_r2: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (state == ST_START && cnt == HALF_CNT && rx) |=> (state == ST_IDLE));
    // R3: the bit count never exceeds one character
    p_nbits_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        nbits <= 4'd8);
    // R4: the stop cell is entered only after eight data samples
    p_stop_after_eight_r4: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (state == ST_STOP && $past(state) == ST_DATA) |-> nbits == 4'd8);
    // R6: after a framing error a low line keeps the FSM waiting
    p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (state == ST_WAIT && !rx) |=> (state == ST_WAIT));
endmodule

// File: rtl/bitclk_rx_outs.sv
`timescale 1ns/1ps
module bitclk_rx_outs
    import bitclk_rx_pkg::*;
#(
    parameter int BIT_CLKS = 2983
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  rx_state_e                     state,
    input  logic [$clog2(BIT_CLKS+1)-1:0] cnt,
    input  logic [3:0]                    nbits,
    input  logic                          take_bit,
    input  logic                          stop_ok,
    input  logic                          rx,
    output logic                          data_q,
    output logic                          dclk_q,
    output logic                          dr_busy
);
    localparam int CW = $clog2(BIT_CLKS + 1);
    localparam int HALF = BIT_CLKS / 2;
    localparam logic [CW-1:0] HALF_LIM = CW'(HALF);
    localparam logic [CW-1:0] FULL = CW'(BIT_CLKS);

    logic [CW-1:0] dr_left;
    logic          in_bit_window;

    assign in_bit_window = ((state == ST_DATA && nbits != 4'd0) || state == ST_STOP)
                           && (cnt < HALF_LIM);
    assign dr_busy = (dr_left != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= 1'b1;
            dclk_q  <= 1'b0;
            dr_left <= '0;
        end else if (clr) begin
            data_q  <= 1'b1;
            dclk_q  <= 1'b0;
            dr_left <= '0;
        end else begin
            if (take_bit) data_q <= rx;
            dclk_q <= in_bit_window;
            if (stop_ok) dr_left <= FULL;
            else if (dr_left != '0) dr_left <= dr_left - 1'b1;
        end
    end

    // R4: each clock rise follows a data sample by exactly one clock
    p_dclk_after_sample_r4: assert property (@(posedge clk) disable iff (!rst_n || clr)
        $rose(dclk_q) |-> $past(take_bit, 2));
    // R5: the strobe begins only on a good stop sample
    p_dr_on_good_stop_r5: assert property (@(posedge clk) disable iff (!rst_n || clr)
        $rose(dr_busy) |-> $past(stop_ok));
    // R5: strobe width counter stays within one cell
    p_dr_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dr_left <= FULL);
endmodule

// File: rtl/bitclk_rx_cdf.sv
`timescale 1ns/1ps
module bitclk_rx_cdf #(
    parameter int CD_CLKS = 28632
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic carrier,
    output logic cd_active
);
    localparam int KW = $clog2(CD_CLKS + 1);
    localparam logic [KW-1:0] K_LAST = KW'(CD_CLKS - 1);

    logic [KW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cd_active <= 1'b0;
            run       <= '0;
        end else if (clr) begin
            cd_active <= 1'b0;
            run       <= '0;
        end else if (carrier != cd_active) begin
            if (run == K_LAST) begin
                cd_active <= carrier;
                run       <= '0;
            end else begin
                run <= run + 1'b1;
            end
        end else begin
            run <= '0;
        end
    end

    // R8: the filtered flag only ever moves toward the raw flag
    p_cd_follows_r8: assert property (@(posedge clk) disable iff (!rst_n || clr)
        !$stable(cd_active) |-> ($past(carrier) == cd_active));
    // R8: the run counter never passes the hysteresis window
    p_cd_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run <= K_LAST);
endmodule

// File: rtl/bitclk_rx.sv
`timescale 1ns/1ps
module bitclk_rx
    import bitclk_rx_pkg::*;
#(
    parameter int CLK_HZ   = 3579545,
    parameter int BAUD     = 1200,
    parameter int CD_MS    = 8,
    parameter int BIT_CLKS = (CLK_HZ + BAUD / 2) / BAUD,
    parameter int CD_CLKS  = (CLK_HZ / 1000) * CD_MS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwdn,
    input  logic rx_in,
    input  logic carrier_in,
    output logic data_out,
    output logic dclk_out,
    output logic dr_n,
    output logic cd_n
);
    localparam int CW = $clog2(BIT_CLKS + 1);

    rx_state_e     state;
    logic [CW-1:0] cnt;
    logic [3:0]    nbits;
    logic          take_bit;
    logic          stop_ok;
    logic          data_q;
    logic          dclk_q;
    logic          dr_busy;
    logic          cd_active;

    bitclk_rx_fsm #(.BIT_CLKS(BIT_CLKS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pwdn),
        .rx       (rx_in),
        .state    (state),
        .cnt      (cnt),
        .nbits    (nbits),
        .take_bit (take_bit),
        .stop_ok  (stop_ok)
    );

    bitclk_rx_outs #(.BIT_CLKS(BIT_CLKS)) u_outs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pwdn),
        .state    (state),
        .cnt      (cnt),
        .nbits    (nbits),
        .take_bit (take_bit),
        .stop_ok  (stop_ok),
        .rx       (rx_in),
        .data_q   (data_q),
        .dclk_q   (dclk_q),
        .dr_busy  (dr_busy)
    );

    bitclk_rx_cdf #(.CD_CLKS(CD_CLKS)) u_cdf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (pwdn),
        .carrier   (carrier_in),
        .cd_active (cd_active)
    );

    // power-down forces the inactive high level on every output
    always_comb begin
        data_out = pwdn | data_q;
        dclk_out = pwdn | dclk_q;
        dr_n     = pwdn | !dr_busy;
        cd_n     = pwdn | !cd_active;
    end

    // R7: a cycle spent in power-down leaves the receiver idle
    p_pwdn_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwdn) |-> (state == ST_IDLE && !dr_busy && !cd_active));
endmodule

// File: tb/bitclk_rx_test.sv
`timescale 1ns/1ps
module bitclk_rx_test;
    localparam int N    = 16;
    localparam int HALF = N / 2;
    localparam int CDK  = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwdn = 1'b0;
    logic rx_in = 1'b1;
    logic carrier_in = 1'b0;
    logic data_out, dclk_out, dr_n, cd_n;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // monitor state
    bit        mon_en = 0;
    int        n_rise, first_rise, first_w, run_hi, n_dr, dr_fall, dr_low, data_lows;
    logic [15:0] cap;
    logic      dclk_prev, dr_prev;

    bitclk_rx #(.BIT_CLKS(N), .CD_CLKS(CDK)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwdn       (pwdn),
        .rx_in      (rx_in),
        .carrier_in (carrier_in),
        .data_out   (data_out),
        .dclk_out   (dclk_out),
        .dr_n       (dr_n),
        .cd_n       (cd_n)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (mon_en) begin
            if (dclk_out && !dclk_prev) begin
                if (n_rise == 0) first_rise = cyc;
                if (n_rise < 16) cap[n_rise] = data_out;
                n_rise++;
            end
            if (dclk_out) run_hi++;
            else begin
                if (dclk_prev && first_w == 0) first_w = run_hi;
                run_hi = 0;
            end
            if (!dr_n && dr_prev) begin
                n_dr++;
                if (n_dr == 1) dr_fall = cyc;
            end
            if (!dr_n) dr_low++;
            if (!data_out) data_lows++;
            dclk_prev = dclk_out;
            dr_prev = dr_n;
        end
    end

    function automatic int exp_first_rise(int t0);
        return t0 + HALF + N + 1;
    endfunction

    function automatic int exp_dr_fall(int t0);
        return t0 + HALF + 9 * N;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        @(posedge clk);
        #1;
        n_rise = 0; first_rise = 0; first_w = 0; run_hi = 0;
        n_dr = 0; dr_fall = 0; dr_low = 0; data_lows = 0; cap = '0;
        dclk_prev = dclk_out; dr_prev = dr_n;
        mon_en = 1;
    endtask

    task automatic send_frame(input logic [7:0] b, input bit stop_hi,
                              input int extra_low, output int t0);
        @(negedge clk);
        rx_in = 1'b0;
        t0 = cyc + 1;
        repeat (N) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_in = b[i];
            repeat (N) @(negedge clk);
        end
        rx_in = stop_hi;
        repeat (N) @(negedge clk);
        if (!stop_hi) begin
            rx_in = 1'b0;
            repeat (extra_low) @(negedge clk);
        end
        rx_in = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_test(input logic [7:0] b, input bit stop_hi,
                              input int extra_low, input int gap);
        int t0;
        clr_mon();
        send_frame(b, stop_hi, extra_low, t0);
        idle(gap);
        chk("R4 rise count", n_rise, 8);
        chk("R3 byte", int'(cap[7:0]), int'(b));
        chk("R3 first rise cycle", first_rise, exp_first_rise(t0));
        chk("R4 pulse width", first_w, HALF);
        if (stop_hi) begin
            chk("R5 strobe count", n_dr, 1);
            chk("R5 strobe start", dr_fall, exp_dr_fall(t0));
            chk("R5 strobe width", dr_low, N);
        end else begin
            chk("R6 no strobe on framing error", n_dr, 0);
        end
    endtask

    initial begin
        int t0a, t0b;
        void'($urandom(32'd1234));
        idle(3);
        // R1 reset state
        chk("R1 data_out", data_out, 1);
        chk("R1 dclk_out", dclk_out, 0);
        chk("R1 dr_n", dr_n, 1);
        chk("R1 cd_n", cd_n, 1);
        rst_n = 1'b1;
        idle(4);

        // directed frames
        frame_test(8'hA5, 1'b1, 0, N + 4);
        frame_test(8'h00, 1'b1, 0, N + 4);
        frame_test(8'hFF, 1'b1, 0, N + 4);

        // R2 false start: short glitch below the half-cell check
        clr_mon();
        @(negedge clk); rx_in = 1'b0;
        repeat (3) @(negedge clk); rx_in = 1'b1;
        idle(2 * N);
        chk("R2 false start no clock", n_rise, 0);
        chk("R2 false start no strobe", n_dr, 0);
        frame_test(8'h3C, 1'b1, 0, N + 4);

        // R6 framing error, line held low, then a good frame
        frame_test(8'h81, 1'b0, 2 * N, N + 4);
        frame_test(8'h5A, 1'b1, 0, N + 4);

        // R9 back-to-back characters
        clr_mon();
        send_frame(8'h12, 1'b1, 0, t0a);
        send_frame(8'hED, 1'b1, 0, t0b);
        idle(N + 4);
        chk("R9 rises for two frames", n_rise, 16);
        chk("R9 two characters", int'(cap), int'(16'hED12));
        chk("R9 two strobes", n_dr, 2);

        // R7 power-down
        @(negedge clk); pwdn = 1'b1; carrier_in = 1'b1;
        @(negedge clk);
        chk("R7 data high", data_out, 1);
        chk("R7 dclk high", dclk_out, 1);
        chk("R7 dr high", dr_n, 1);
        chk("R7 cd high", cd_n, 1);
        clr_mon();
        send_frame(8'h00, 1'b1, 0, t0a);
        idle(CDK + N);
        chk("R7 no clock edges", n_rise, 0);
        chk("R7 no strobe", n_dr, 0);
        chk("R7 data never low", data_lows, 0);
        chk("R7 carrier ignored", cd_n, 1);
        @(negedge clk); pwdn = 1'b0; carrier_in = 1'b0;
        @(negedge clk);
        chk("R7 release dclk", dclk_out, 0);
        chk("R7 release dr", dr_n, 1);
        chk("R7 release cd", cd_n, 1);
        frame_test(8'hC3, 1'b1, 0, N + 4);

        // R8 carrier hysteresis, exact edge
        @(negedge clk); carrier_in = 1'b1;
        repeat (CDK - 1) @(negedge clk);
        chk("R8 not yet asserted", cd_n, 1);
        @(negedge clk);
        chk("R8 asserted after window", cd_n, 0);
        for (int k = 0; k < 6; k++) begin
            int d;
            d = 1 + int'($urandom % (CDK - 1));
            carrier_in = 1'b0;
            repeat (d) @(negedge clk);
            carrier_in = 1'b1;
            @(negedge clk);
            chk("R8 short dropout ignored", cd_n, 0);
        end
        carrier_in = 1'b0;
        repeat (CDK - 1) @(negedge clk);
        chk("R8 not yet released", cd_n, 0);
        @(negedge clk);
        chk("R8 released after window", cd_n, 1);

        // random frames
        for (int k = 0; k < 24; k++) begin
            logic [7:0] b;
            bit sh;
            b = 8'($urandom);
            sh = (($urandom % 8) != 0);
            frame_test(b, sh, int'($urandom % N), N + int'($urandom % N));
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule